// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block guards a system against runaway software. A 13-bit prescaler counts timer-clock enables. A selectable tap from its upper bits steps an 8-bit main counter downward. When the main counter is already at zero and another step arrives, the block issues a one-cycle system reset request and sets a sticky timeout flag. It then reloads the counter from a software-visible reload register and clears the prescaler. Software keeps the system alive by "feeding" the watchdog. A feed is a write of A5h to the first key register followed directly by a write of 5Ah to the second key register. A valid feed reloads the counter and clears the prescaler. A broken key sequence is treated as a software fault and triggers an immediate reset request.

Changes to the control register (prescaler select and run bit) go to a shadow copy. They become active only at the next valid feed, and this includes stopping the watchdog. After an external reset the watchdog is running with the longest divisor and a reload value of zero.

The register port is a plain single-cycle access port: one read or write per clock, with no back-pressure. Every access completes in the cycle it is presented, so no valid/ready handshake is needed. The reset request and the timeout flag are plain status outputs.

Top module: `wdog_keyed`

## Requirements
- R1: Register map on `acc_addr`: 0 is control, read as {flag at bit 7, zeros at bits 6:4, active run at bit 3, active select at bits 2:0}. 1 is the reload value, which can be read and written. 2 is the first key on write and reads back the main counter. 3 is the second key on write and reads as 00h. Read data is combinational.
- R2: With active select s, the main counter decrements once every 32·2^s ticks of `tick_en`. Cycles without `tick_en` do not advance the prescaler.
- R3: When a step arrives with the counter at zero, `wdog_rst_req` is high for exactly the following cycle, the flag is set, the counter reloads and the prescaler clears. The next timeout therefore follows (W+1)·32·2^s ticks later, where W is the reload value.
- R4: A reload value of 00h is legal. The timeout after an autoload is then exactly one divisor period.
- R5: A write of A5h to address 2, followed as the next register access by a write of 5Ah to address 3, is a valid feed. It reloads the counter from the reload register, clears the prescaler and raises no reset. Idle cycles between the two writes are allowed.
- R6: Once A5h has been written to address 2, any next access other than a write of 5Ah to address 3 is a fault. This includes reads, wrong data, other addresses and a repeated first key. A fault raises `wdog_rst_req` in the cycle after that access and sets the flag.
- R7: A write to address 2 with data other than A5h does not arm the sequence and raises no reset. A write of 5Ah to address 3 without a preceding armed key neither reloads the counter nor raises a reset.
- R8: Writes to the control register's select and run fields have no visible effect until the next valid feed, which applies them.
- R9: While the active run bit is 0, the prescaler and the main counter hold and no timeout occurs.
- R10: After external reset the control register reads 0Fh, the reload register and the counter read 00h, and the first timeout comes 4096 ticks later.
- R11: The flag stays set until a control write with bit 7 equal to 0 clears it. A control write with bit 7 equal to 1 leaves it unchanged.
- R12: External reset asserted at the point where an underflow would occur leaves the flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, asynchronous, active low |
| tick_en | input | 1 | Timer-clock enable that advances the prescaler |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe (counts as an access for the key sequence) |
| acc_addr | input | 2 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for `acc_addr` |
| wdog_rst_req | output | 1 | One-cycle system reset request |
| timeout_flag | output | 1 | Sticky timeout flag |

## Verification
The hardest condition to reach from the ports is an underflow that lands exactly on an external reset. To get there, the stimulus stops the tick enable, loads a zero reload value with the shortest divisor, and feeds so that the prescaler starts from zero at a known edge. It then counts tick cycles and drops reset just before the predicted underflow edge. Key faults caused by reads are reached by placing a read between the two key writes while ticks are stopped, so that a timeout cannot be mistaken for the fault pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int SEL_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_RELOAD = 2'd1,
    A_KEY1   = 2'd2,
    A_KEY2   = 2'd3
  } wd_addr_e;

  localparam logic [DATA_W-1:0] KEY_ARM  = 8'hA5;
  localparam logic [DATA_W-1:0] KEY_FIRE = 8'h5A;

  localparam int CTL_RUN_BIT  = 3;
  localparam int CTL_FLAG_BIT = 7;

  typedef struct packed {
    logic             run;
    logic [SEL_W-1:0] sel;
  } wd_ctl_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W    = 13,
  parameter int SEL_W    = 3,
  parameter int TAP_BASE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);
  localparam int NTAP = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [NTAP-1:0]  tap_full;

  // each tap fires when all bits below it are ones, i.e. on the carry into it
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign tap_full[g] = &pre_q[TAP_BASE+g-1:0];
  end

  assign step = run & tick_en & tap_full[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre_q <= '0;
    else if (clr)             pre_q <= '0;
    else if (run && tick_en)  pre_q <= pre_q + 1'b1;
  end

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pre_q));

  p_notick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             underflow
);
  logic [CNT_W-1:0] cnt_q;

  assign underflow = step & ~load & (cnt_q == '0);
  assign cnt       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (step) begin
      if (cnt_q == '0)      cnt_q <= load_val;
      else                  cnt_q <= cnt_q - 1'b1;
    end
  end

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (cnt_q == $past(load_val)));

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              feed_ok,
  output logic              key_fault
);
  logic armed_q;
  logic access;
  logic second_ok;
  logic arm_set;

  assign access    = wr | rd;
  assign second_ok = wr && (addr == A_KEY2) && (wdata == KEY_FIRE);
  assign arm_set   = wr && (addr == A_KEY1) && (wdata == KEY_ARM);
  assign feed_ok   = armed_q & second_ok;
  assign key_fault = armed_q & access & ~second_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 armed_q <= 1'b0;
    else if (armed_q && access) armed_q <= 1'b0;
    else if (arm_set)           armed_q <= 1'b1;
  end

  p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && access) |=> !armed_q);

  p_noarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !arm_set) |=> !armed_q);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int PRE_W    = 13,
  parameter int CNT_W    = 8,
  parameter int TAP_BASE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              wdog_rst_req,
  output logic              timeout_flag
);
  localparam wd_ctl_t CTL_RST = '{run: 1'b1, sel: '1};

  wd_ctl_t          ctl_act, ctl_shd;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_w;
  logic             flag_q;
  logic             rst_req_q;
  logic             feed_ok, key_fault;
  logic             step, underflow;
  logic             wr_ctrl, wr_reload;

  assign wr_ctrl   = acc_wr && (acc_addr == A_CTRL);
  assign wr_reload = acc_wr && (acc_addr == A_RELOAD);

  wdog_keyseq u_keys (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (acc_wr),
    .rd        (acc_rd),
    .addr      (acc_addr),
    .wdata     (acc_wdata),
    .feed_ok   (feed_ok),
    .key_fault (key_fault)
  );

  wdog_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W), .TAP_BASE(TAP_BASE)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl_act.run),
    .tick_en (tick_en),
    .clr     (feed_ok | underflow),
    .sel     (ctl_act.sel),
    .step    (step)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (feed_ok),
    .load_val  (reload_q),
    .step      (step),
    .cnt       (cnt_w),
    .underflow (underflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_act   <= CTL_RST;
      ctl_shd   <= CTL_RST;
      reload_q  <= '0;
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= underflow | key_fault;
      if (wr_ctrl)
        ctl_shd <= '{run: acc_wdata[CTL_RUN_BIT], sel: acc_wdata[SEL_W-1:0]};
      if (feed_ok)
        ctl_act <= ctl_shd;
      if (wr_reload)
        reload_q <= acc_wdata[CNT_W-1:0];
      if (underflow || key_fault)
        flag_q <= 1'b1;
      else if (wr_ctrl && !acc_wdata[CTL_FLAG_BIT])
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    acc_rdata = '0;
    unique case (acc_addr)
      A_CTRL: begin
        acc_rdata[CTL_FLAG_BIT]  = flag_q;
        acc_rdata[CTL_RUN_BIT]   = ctl_act.run;
        acc_rdata[SEL_W-1:0]     = ctl_act.sel;
      end
      A_RELOAD: acc_rdata[CNT_W-1:0] = reload_q;
      A_KEY1:   acc_rdata[CNT_W-1:0] = cnt_w;
      default:  acc_rdata = '0;
    endcase
  end

  assign wdog_rst_req = rst_req_q;
  assign timeout_flag = flag_q;

  p_flag_on_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> flag_q);

  p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_ok |=> (ctl_act == $past(ctl_act)));

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_act.run && !feed_ok) |=> $stable(cnt_w));

  p_feed_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> !rst_req_q);

  p_feed_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> (cnt_w == $past(reload_q)));
endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       acc_wr = 1'b0;
  logic       acc_rd = 1'b0;
  logic [1:0] acc_addr = 2'd0;
  logic [7:0] acc_wdata = 8'd0;
  logic [7:0] acc_rdata;
  logic       wdog_rst_req;
  logic       timeout_flag;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 0;
  int    exp_q[$];
  string tag_q[$];

  wdog_keyed uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .acc_wr       (acc_wr),
    .acc_rd       (acc_rd),
    .acc_addr     (acc_addr),
    .acc_wdata    (acc_wdata),
    .acc_rdata    (acc_rdata),
    .wdog_rst_req (wdog_rst_req),
    .timeout_flag (timeout_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected pulse cycle for every reset request seen
  always @(negedge clk) begin
    if (rst_n && wdog_rst_req && !done) begin
      if (exp_q.size() == 0) begin
        check(0, "R3/R6 unexpected reset pulse at cycle", cyc, -1);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(e == cyc, t, cyc, e);
      end
    end
  end

  task automatic push(input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // all tasks start and end at a negedge; the access edge equals cyc on return
  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int edge_n);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
    edge_n = cyc;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_rd = 1'b1; acc_addr = a;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_rd = 1'b0;
  endtask

  task automatic feed(output int f);
    int e;
    wr(2'd2, 8'hA5, e);
    wr(2'd3, 8'h5A, f);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      check(0, "watchdog expired", cyc, 0);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d0;
    int e, f, c;

    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R10 / R1 reset state
    rd(2'd0, d); check(d == 8'h0F, "R10 R1 control after reset", d, 8'h0F);
    rd(2'd1, d); check(d == 8'h00, "R10 reload after reset", d, 8'h00);
    rd(2'd2, d); check(d == 8'h00, "R10 counter after reset", d, 8'h00);
    rd(2'd3, d); check(d == 8'h00, "R1 second key reads zero", d, 8'h00);
    check(!timeout_flag, "R10 flag after reset", timeout_flag, 0);

    // R10 default timeout 4096 ticks
    tick_en = 1'b1;
    push(cyc + 4096, "R10 default timeout cycle");
    idle(4100);
    tick_en = 1'b0;
    rd(2'd0, d); check(d == 8'h8F, "R3 R11 flag set after timeout", d, 8'h8F);

    // R11 sticky flag
    wr(2'd0, 8'h8F, e);
    rd(2'd0, d); check(d == 8'h8F, "R11 write 1 keeps flag", d, 8'h8F);
    wr(2'd0, 8'h0F, e);
    rd(2'd0, d); check(d == 8'h0F, "R11 write 0 clears flag", d, 8'h0F);

    // R8 pending control
    wr(2'd0, 8'h08, e);
    rd(2'd0, d); check(d == 8'h0F, "R8 control held before feed", d, 8'h0F);
    wr(2'd1, 8'h03, e);
    feed(f);
    rd(2'd0, d); check(d == 8'h08, "R8 control applied on feed", d, 8'h08);
    rd(2'd2, d); check(d == 8'h03, "R5 feed reloads counter", d, 8'h03);

    // R2 step spacing: 40 ticks at divisor 32 -> one decrement
    tick_en = 1'b1;
    idle(40);
    tick_en = 1'b0;
    rd(2'd2, d); check(d == 8'h02, "R2 one step after 40 ticks", d, 8'h02);

    // R3 periodic timeout with reload 3, divisor 32
    feed(f);
    tick_en = 1'b1;
    c = cyc;
    push(c + 128, "R3 first timeout (W+1)*32");
    push(c + 256, "R3 reload gives second timeout");
    idle(260);
    tick_en = 1'b0;
    rd(2'd2, d); check(d == 8'h03, "R3 counter reloaded", d, 8'h03);
    wr(2'd0, 8'h08, e);

    // R4 reload zero -> one divisor period
    wr(2'd1, 8'h00, e);
    feed(f);
    tick_en = 1'b1;
    push(cyc + 32, "R4 zero reload timeout");
    idle(40);
    tick_en = 1'b0;
    wr(2'd0, 8'h08, e);

    // R5 periodic feeding prevents timeout
    wr(2'd1, 8'h03, e);
    tick_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      feed(f);
      idle(100);
    end
    feed(f);
    push(f + 128, "R5 timeout after last feed");
    idle(140);
    tick_en = 1'b0;
    wr(2'd0, 8'h08, e);

    // R6 key faults
    wr(2'd2, 8'hA5, e);
    push(cyc + 2, "R6 fault on write to other register");
    wr(2'd1, 8'h07, e);
    rd(2'd0, d); check(d[7] == 1'b1, "R6 fault sets flag", d[7], 1);
    wr(2'd0, 8'h08, e);
    wr(2'd2, 8'hA5, e);
    push(cyc + 2, "R6 fault on intervening read");
    rd(2'd1, d);
    wr(2'd2, 8'hA5, e);
    push(cyc + 2, "R6 fault on wrong second key");
    wr(2'd3, 8'h5B, e);
    wr(2'd2, 8'hA5, e);
    push(cyc + 2, "R6 fault on repeated first key");
    wr(2'd2, 8'hA5, e);
    wr(2'd0, 8'h08, e);

    // R7 wrong first key does not arm
    wr(2'd1, 8'h09, e);
    rd(2'd2, d0);
    wr(2'd2, 8'h5A, e);
    wr(2'd3, 8'h5A, e);
    idle(3);
    rd(2'd2, d); check(d == d0, "R7 unarmed second key no reload", d, d0);
    rd(2'd0, d); check(d[7] == 1'b0, "R7 no fault flag", d[7], 0);
    feed(f);
    rd(2'd2, d); check(d == 8'h09, "R5 armed feed reloads", d, 8'h09);

    // R9 stopped watchdog holds
    wr(2'd0, 8'h00, e);
    rd(2'd0, d); check(d == 8'h08, "R8 stop held before feed", d, 8'h08);
    feed(f);
    rd(2'd0, d); check(d == 8'h00, "R9 stop applied", d, 8'h00);
    tick_en = 1'b1;
    idle(5000);
    tick_en = 1'b0;
    rd(2'd2, d); check(d == 8'h09, "R9 counter held while stopped", d, 8'h09);
    wr(2'd0, 8'h08, e);
    wr(2'd1, 8'h00, e);
    feed(f);

    // R12 reset on the underflow edge
    tick_en = 1'b1;
    idle(31);
    rst_n = 1'b0;
    idle(2);
    tick_en = 1'b0;
    rst_n = 1'b1;
    idle(1);
    rd(2'd0, d); check(d == 8'h0F, "R12 flag clear after reset at underflow", d, 8'h0F);
    check(!timeout_flag, "R12 flag pin low", timeout_flag, 0);

    idle(5);
    check(exp_q.size() == 0, "R3 missing expected pulses", exp_q.size(), 0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule